// File: doc/BRIEF.md
# Multi-PHY Transmit Cell Poller

This block is the master side of a shared-bus transmit cell interface that serves many PHY ports. It puts port addresses on a 5-bit address bus and reads back each port's cell-available line. It then picks one ready port in round-robin order. It addresses that port, drives that port's active-low enable strobe and sends one fixed-length cell. The cell goes out on an 8-bit or 16-bit data bus, with a start-of-cell marker and an odd parity bit on every transfer. A bitmap of connected addresses decides which addresses are polled. Unconnected addresses never appear on the bus.

There are two modes. In basic mode one cell-available line and one enable line serve up to 31 ports. In extended mode eight cell-available and eight enable groups share the same address, which gives up to 248 ports. The port index is `addr*8 + group`. After reset the block is disabled and its pad enable `bus_oe` is low. Software sets the width and the mode, then raises `cfg_en`. Width and mode are captured only at that moment.

Top module: `up_tx_poller`

## Requirements
- R1: After reset, and for as long as `cfg_en` is low, `bus_oe` is 0, every `bus_enb_n` bit is 1, `src_take` is 0 and `bus_addr` is 31.
- R2: `bus_oe` rises one clock after `cfg_en` is sampled high. It falls one clock after `cfg_en` is sampled low, even in the middle of a cell.
- R3: The only address values that appear on `bus_addr` are 31 (the null address) and addresses whose bit is set in `cfg_portmap`. Each polled address is followed by one null cycle. The cell-available response is sampled at the end of that null cycle.
- R4: In basic mode (`cfg_ext`=0 when enabled), only `phy_clav[0]` is used. `phy_clav[7:1]` have no effect on port selection, and `bus_enb_n[7:1]` stay at 1.
- R5: In extended mode (`cfg_ext`=1 when enabled), `phy_clav[g]` reports port `addr*8+g`. A cell for port `p` is preceded by one cycle with `bus_addr = p/8` and all enables high. During the cell, only `bus_enb_n[p%8]` is 0.
- R6: After each full poll sweep, the port served is the lowest-indexed ready port above the last port served, wrapping to the lowest ready index. After each enable, the search starts from index 0.
- R7: A cell keeps exactly one `bus_enb_n` bit low for consecutive cycles: 53 cycles in 8-bit mode and 27 cycles in 16-bit mode. `src_take` is 1 and `src_port` holds the port index on each of those cycles only.
- R8: `bus_soc` is 1 on the first transfer cycle of a cell and 0 on all other cycles.
- R9: In 8-bit mode, `bus_data[7:0]` equals `src_data[7:0]` and `bus_data[15:8]` is 0. `bus_prty` gives odd parity over the low 8 bits.
- R10: In 16-bit mode, `bus_data` equals `src_data`, and `bus_prty` gives odd parity over all 16 bits.
- R11: Changing `cfg_wide` or `cfg_ext` while enabled does not change cell length, data masking or mode until `cfg_en` has been low and is raised again.
- R12: With an empty `cfg_portmap`, the enabled block holds `bus_addr` at 31 and sends no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Block enable and pad release |
| cfg_wide | input | 1 | 1 = 16-bit data bus, 0 = 8-bit, captured at enable |
| cfg_ext | input | 1 | 1 = extended eight-group mode, captured at enable |
| cfg_portmap | input | 31 | Connected-address bitmap, bit n = address n |
| phy_clav | input | 8 | Cell-available lines, one per group |
| src_data | input | 16 | Cell data word offered by the upstream buffer |
| src_take | output | 1 | Current `src_data` is consumed this cycle |
| src_port | output | 8 | Port index of the cell being sent |
| bus_oe | output | 1 | Pad drive enable; 0 means outputs are high impedance |
| bus_addr | output | 5 | Port address bus, 31 = null |
| bus_enb_n | output | 8 | Active-low transmit enables, one per group |
| bus_data | output | 16 | Transmit data |
| bus_soc | output | 1 | Start of cell |
| bus_prty | output | 1 | Odd parity over the valid data bits |

## Verification
A bad sweep pointer shows up within one poll slot as an unconnected address on `bus_addr`. A corrupt ready vector or round-robin pointer shows up on the first following cell as a wrong `src_port` or a wrong enable bit. A wrong beat counter or a wrong captured width is seen when the cell ends, as a wrong enable-low run length. A wrong start marker is seen on the first transfer cycle. Masking and parity faults are visible on the same cycle as the faulty transfer.

// File: rtl/up_poll_pkg.sv
package up_poll_pkg;

   typedef enum logic [2:0] {
      ST_OFF,    // pads released, waiting for enable
      ST_POLL,   // poll address on the bus
      ST_GAP,    // null address, response sampled at end
      ST_ARB,    // sweep done, choose a port
      ST_SEL,    // selected address on the bus, enables high
      ST_XFER    // cell transfer
   } up_state_e;

endpackage

// File: rtl/up_next_conn.sv
// Finds the lowest connected address, either from zero or strictly above a
// given address.
module up_next_conn #(
   parameter int NADDR = 31,
   parameter int AW    = 5
) (
   input  logic [NADDR-1:0] map,
   input  logic [AW-1:0]    from_addr,
   input  logic             from_zero,
   output logic             found,
   output logic [AW-1:0]    addr
);

   always_comb begin
      found = 1'b0;
      addr  = '0;
      for (int i = 0; i < NADDR; i++) begin
         if (!found && map[i] && (from_zero || i > int'(from_addr))) begin
            found = 1'b1;
            addr  = AW'(i);
         end
      end
   end

endmodule

// File: rtl/up_rr_pick.sv
// Round-robin choice: lowest request above the last grant, else lowest overall.
module up_rr_pick #(
   parameter int N  = 248,
   parameter int IW = 8
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          any,
   output logic [IW-1:0] pick
);

   logic          hi_hit;
   logic [IW-1:0] hi_idx;
   logic [IW-1:0] lo_idx;

   always_comb begin
      hi_hit = 1'b0;
      any    = 1'b0;
      hi_idx = '0;
      lo_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            any    = 1'b1;
            lo_idx = IW'(i);
         end
         if (req[i] && !hi_hit && i > int'(last)) begin
            hi_hit = 1'b1;
            hi_idx = IW'(i);
         end
      end
      pick = hi_hit ? hi_idx : lo_idx;
   end

endmodule

// File: rtl/up_cell_frame.sv
// Transfer-cycle framing: lane masking, start marker and parity.
module up_cell_frame #(
   parameter int DW         = 16,
   parameter bit PARITY_ODD = 1'b1
) (
   input  logic          active,
   input  logic          wide,
   input  logic          first,
   input  logic [DW-1:0] src,
   output logic [DW-1:0] data,
   output logic          soc,
   output logic          prty
);

   localparam int HW = DW / 2;

   always_comb begin
      if (!active)   data = '0;
      else if (wide) data = src;
      else           data = {{(DW-HW){1'b0}}, src[HW-1:0]};
   end

   assign soc = active && first;

   generate
      if (PARITY_ODD) begin : g_odd
         assign prty = ~^data;
      end else begin : g_even
         assign prty = ^data;
      end
   endgenerate

endmodule

// File: rtl/up_tx_poller.sv
module up_tx_poller
   import up_poll_pkg::*;
#(
   parameter int AW         = 5,
   parameter int NGRP       = 8,
   parameter int DW         = 16,
   parameter int CELL_BYTES = 53,
   parameter bit PARITY_ODD = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    cfg_en,
   input  logic                                    cfg_wide,
   input  logic                                    cfg_ext,
   input  logic [(1<<AW)-2:0]                      cfg_portmap,
   input  logic [NGRP-1:0]                         phy_clav,
   input  logic [DW-1:0]                           src_data,
   output logic                                    src_take,
   output logic [$clog2(((1<<AW)-1)*NGRP)-1:0]     src_port,
   output logic                                    bus_oe,
   output logic [AW-1:0]                           bus_addr,
   output logic [NGRP-1:0]                         bus_enb_n,
   output logic [DW-1:0]                           bus_data,
   output logic                                    bus_soc,
   output logic                                    bus_prty
);

   localparam int NADDR      = (1 << AW) - 1;
   localparam int NPORT      = NADDR * NGRP;
   localparam int IW         = $clog2(NPORT);
   localparam int GW         = $clog2(NGRP);
   localparam int CELL_WORDS = (CELL_BYTES + 1) / 2;
   localparam int CW         = $clog2(CELL_BYTES + 1);
   localparam logic [AW-1:0] NULLA = '1;

   generate
      if (AW < 2 || AW > 8) begin : g_bad_aw
         $error("up_tx_poller: AW must lie in 2..8");
      end
      if (NGRP < 2 || NGRP > 8) begin : g_bad_ngrp
         $error("up_tx_poller: NGRP must lie in 2..8");
      end
      if (DW < 2 || (DW % 2) != 0) begin : g_bad_dw
         $error("up_tx_poller: DW must be even and at least 2");
      end
      if (CELL_BYTES < 2) begin : g_bad_cell
         $error("up_tx_poller: CELL_BYTES must be at least 2");
      end
   endgenerate

   up_state_e       st;
   logic [AW-1:0]   cur_addr;
   logic            lat_wide;
   logic            lat_ext;
   logic [NPORT-1:0] ready;
   logic [IW-1:0]   last_idx;
   logic [IW-1:0]   sel_idx;
   logic [CW-1:0]   cnt;

   logic            nc_found;
   logic [AW-1:0]   nc_addr;
   logic            rr_any;
   logic [IW-1:0]   rr_pick;
   logic [AW-1:0]   sel_addr;
   logic [GW-1:0]   sel_grp;
   logic            cell_last;
   logic            xfer;

   up_next_conn #(.NADDR(NADDR), .AW(AW)) i_next (
      .map       (cfg_portmap),
      .from_addr (cur_addr),
      .from_zero (st != ST_GAP),
      .found     (nc_found),
      .addr      (nc_addr)
   );

   up_rr_pick #(.N(NPORT), .IW(IW)) i_rr (
      .req  (ready),
      .last (last_idx),
      .any  (rr_any),
      .pick (rr_pick)
   );

   assign sel_addr  = AW'(sel_idx / IW'(NGRP));
   assign sel_grp   = GW'(sel_idx % IW'(NGRP));
   assign xfer      = (st == ST_XFER);
   assign cell_last = (cnt == (lat_wide ? CW'(CELL_WORDS - 1) : CW'(CELL_BYTES - 1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_OFF;
         cur_addr <= NULLA;
         lat_wide <= 1'b0;
         lat_ext  <= 1'b0;
         ready    <= '0;
         last_idx <= IW'(NPORT - 1);
         sel_idx  <= '0;
         cnt      <= '0;
      end else if (!cfg_en) begin
         st       <= ST_OFF;
         cur_addr <= NULLA;
         ready    <= '0;
         last_idx <= IW'(NPORT - 1);
      end else begin
         case (st)
            ST_OFF: begin
               lat_wide <= cfg_wide;
               lat_ext  <= cfg_ext;
               st       <= nc_found ? ST_POLL : ST_ARB;
               cur_addr <= nc_found ? nc_addr : NULLA;
            end
            ST_POLL: st <= ST_GAP;
            ST_GAP: begin
               for (int g = 0; g < NGRP; g++) begin
                  if ((g == 0 || lat_ext) && phy_clav[g])
                     ready[int'(cur_addr) * NGRP + g] <= 1'b1;
               end
               st       <= nc_found ? ST_POLL : ST_ARB;
               cur_addr <= nc_found ? nc_addr : NULLA;
            end
            ST_ARB: begin
               ready <= '0;
               if (rr_any) begin
                  sel_idx  <= rr_pick;
                  last_idx <= rr_pick;
                  cnt      <= '0;
                  st       <= ST_SEL;
               end else begin
                  st       <= nc_found ? ST_POLL : ST_ARB;
                  cur_addr <= nc_found ? nc_addr : NULLA;
               end
            end
            ST_SEL: st <= ST_XFER;
            ST_XFER: begin
               cnt <= cnt + 1'b1;
               if (cell_last) begin
                  st       <= nc_found ? ST_POLL : ST_ARB;
                  cur_addr <= nc_found ? nc_addr : NULLA;
               end
            end
            default: st <= ST_OFF;
         endcase
      end
   end

   assign bus_oe   = (st != ST_OFF);
   assign bus_addr = (st == ST_POLL) ? cur_addr :
                     (st == ST_SEL)  ? sel_addr : NULLA;
   assign src_take = xfer;
   assign src_port = sel_idx;

   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_enb
         assign bus_enb_n[g] = !(xfer && sel_grp == GW'(g));
      end
   endgenerate

   up_cell_frame #(.DW(DW), .PARITY_ODD(PARITY_ODD)) i_frame (
      .active (xfer),
      .wide   (lat_wide),
      .first  (cnt == '0),
      .src    (src_data),
      .data   (bus_data),
      .soc    (bus_soc),
      .prty   (bus_prty)
   );

endmodule

// File: rtl/up_tx_poller_chk.sv
module up_tx_poller_chk #(
   parameter int AW   = 5,
   parameter int NGRP = 8,
   parameter int DW   = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_en,
   input logic [(1<<AW)-2:0]   cfg_portmap,
   input logic                 lat_wide,
   input logic                 lat_ext,
   input logic                 src_take,
   input logic                 bus_oe,
   input logic [AW-1:0]        bus_addr,
   input logic [NGRP-1:0]      bus_enb_n,
   input logic [DW-1:0]        bus_data,
   input logic                 bus_soc
);

   localparam logic [AW-1:0] NULLA = '1;
   logic [(1<<AW)-1:0] mapx;
   assign mapx = {1'b0, cfg_portmap};

   p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (&bus_enb_n && !src_take && bus_addr == NULLA));

   p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> !bus_oe);

   p_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !bus_oe) |=> bus_oe);

   p_conn_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && bus_addr != NULLA) |-> mapx[bus_addr]);

   p_basic_enb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !lat_ext) |-> &bus_enb_n[NGRP-1:1]);

   p_one_enb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_enb_n));

   p_take_enb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      src_take |-> !(&bus_enb_n));

   p_soc_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_soc |-> ($past(&bus_enb_n) && !(&bus_enb_n)));

   p_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !lat_wide) |-> (bus_data[DW-1:DW/2] == '0));

   p_hold_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && $past(bus_oe)) |-> ($stable(lat_wide) && $stable(lat_ext)));

endmodule

bind up_tx_poller up_tx_poller_chk #(.AW(AW), .NGRP(NGRP), .DW(DW)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_en      (cfg_en),
   .cfg_portmap (cfg_portmap),
   .lat_wide    (lat_wide),
   .lat_ext     (lat_ext),
   .src_take    (src_take),
   .bus_oe      (bus_oe),
   .bus_addr    (bus_addr),
   .bus_enb_n   (bus_enb_n),
   .bus_data    (bus_data),
   .bus_soc     (bus_soc)
);

// File: tb/test_up_tx_poller.sv
module test_up_tx_poller;

   localparam int NADDR = 31;
   localparam int NPORT = 248;
   localparam logic [4:0] NULLA = 5'd31;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_en;
   logic        cfg_wide;
   logic        cfg_ext;
   logic [30:0] cfg_portmap;
   logic [7:0]  phy_clav;
   logic [15:0] src_data;
   logic        src_take;
   logic [7:0]  src_port;
   logic        bus_oe;
   logic [4:0]  bus_addr;
   logic [7:0]  bus_enb_n;
   logic [15:0] bus_data;
   logic        bus_soc;
   logic        bus_prty;

   always #5 clk = ~clk;

   up_tx_poller i_up_tx_poller (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wide(cfg_wide),
      .cfg_ext(cfg_ext), .cfg_portmap(cfg_portmap), .phy_clav(phy_clav),
      .src_data(src_data), .src_take(src_take), .src_port(src_port),
      .bus_oe(bus_oe), .bus_addr(bus_addr), .bus_enb_n(bus_enb_n),
      .bus_data(bus_data), .bus_soc(bus_soc), .bus_prty(bus_prty)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int n_cells = 0;
   logic [NPORT-1:0] rdy_vec;
   bit   exp_wide, exp_ext;
   bit   mon_on;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Expected round-robin choice from the requirement text (R6)
   function automatic int rr_next(input int last);
      for (int k = 1; k <= NPORT; k++) begin
         int j;
         j = (last + k + NPORT) % NPORT;
         if (rdy_vec[j] && cfg_portmap[j / 8] && (exp_ext || (j % 8) == 0))
            return j;
      end
      return -1;
   endfunction

   task automatic fill_rdy(input int a, input int b, input int thr);
      for (int i = 0; i < NPORT; i++) rdy_vec[i] = ((i * a + b) % 7) < thr;
   endtask

   // PHY model, data source and port monitor in one negedge loop
   initial begin
      logic [4:0] seen_addr;
      logic [4:0] prev_bus;
      bit   in_cell;
      int   cnt, exp_port, exp_last;
      seen_addr = NULLA; prev_bus = NULLA;
      in_cell = 0; cnt = 0; exp_port = 0; exp_last = -1;
      phy_clav = '0; src_data = 16'h1234;
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (!bus_oe) begin
               in_cell = 0;
               exp_last = -1;
            end else begin
               if (bus_addr != NULLA)
                  chk(cfg_portmap[bus_addr] == 1'b1, "R3 address connected", bus_addr, 1);
               if (!exp_ext)
                  chk(bus_enb_n[7:1] == 7'h7F, "R4 upper enables idle", bus_enb_n, 8'hFF);
               chk($countones(~bus_enb_n) <= 1, "R7 one enable", bus_enb_n, 0);
               if (!(&bus_enb_n)) begin
                  logic [15:0] exp_d;
                  logic [7:0]  oh;
                  if (!in_cell) begin
                     exp_port = rr_next(exp_last);
                     exp_last = exp_port;
                     chk(prev_bus == 5'(exp_port / 8), "R5 select address", prev_bus, exp_port / 8);
                     chk(bus_soc == 1'b1, "R8 soc on first", bus_soc, 1);
                     in_cell = 1;
                     cnt = 1;
                     n_cells++;
                  end else begin
                     chk(bus_soc == 1'b0, "R8 soc only first", bus_soc, 0);
                     cnt++;
                  end
                  chk(int'(src_port) == exp_port, "R6 port chosen", src_port, exp_port);
                  oh = 8'(1 << (exp_port % 8));
                  chk(bus_enb_n == ~oh, "R5 enable group", bus_enb_n, ~oh);
                  chk(src_take == 1'b1, "R7 take during cell", src_take, 1);
                  exp_d = exp_wide ? src_data : {8'h00, src_data[7:0]};
                  chk(bus_data == exp_d, exp_wide ? "R10 data" : "R9 data", bus_data, exp_d);
                  chk((^{bus_data, bus_prty}) == 1'b1, exp_wide ? "R10 parity" : "R9 parity",
                      bus_prty, ~^bus_data);
               end else begin
                  if (in_cell)
                     chk(cnt == (exp_wide ? 27 : 53), "R7 R11 cell length", cnt, exp_wide ? 27 : 53);
                  in_cell = 0;
                  chk(src_take == 1'b0, "R7 take idle", src_take, 0);
               end
            end
         end
         prev_bus = bus_addr;
         // PHY answers one clock after its address
         phy_clav = (seen_addr == NULLA) ? 8'h00 : rdy_vec[int'(seen_addr) * 8 +: 8];
         seen_addr = bus_addr;
         src_data = 16'(src_data * 16'd25173 + 16'd13849);
      end
   end

   task automatic run_cells(input int n);
      int tgt;
      tgt = n_cells + n;
      while (n_cells < tgt) @(negedge clk);
   endtask

   task automatic enable_with(input bit w, input bit e);
      @(negedge clk);
      cfg_wide = w; cfg_ext = e; exp_wide = w; exp_ext = e;
      cfg_en = 1'b1;
      chk(bus_oe == 1'b0, "R2 no drive before edge", bus_oe, 0);
      @(negedge clk);
      chk(bus_oe == 1'b1, "R2 drive one clock after enable", bus_oe, 1);
   endtask

   task automatic disable_now();
      @(negedge clk);
      cfg_en = 1'b0;
      @(negedge clk);
      chk(bus_oe == 1'b0, "R2 release one clock after disable", bus_oe, 0);
      chk(bus_enb_n == 8'hFF, "R1 enables idle when off", bus_enb_n, 8'hFF);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; cfg_en = 1'b0; cfg_wide = 1'b0; cfg_ext = 1'b0;
      cfg_portmap = '0; rdy_vec = '0; exp_wide = 0; exp_ext = 0; mon_on = 0;
      repeat (3) @(negedge clk);
      chk(bus_oe == 1'b0, "R1 oe in reset", bus_oe, 0);
      chk(bus_enb_n == 8'hFF, "R1 enables in reset", bus_enb_n, 8'hFF);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(bus_oe == 1'b0, "R1 oe while disabled", bus_oe, 0);
      chk(src_take == 1'b0, "R1 take while disabled", src_take, 0);
      chk(bus_addr == NULLA, "R1 null address while disabled", bus_addr, NULLA);
      mon_on = 1;

      // Basic mode, 8-bit, clav noise on upper groups (R4, R6, R9)
      cfg_portmap = 31'h6A5C_3A91;
      fill_rdy(3, 1, 3);
      enable_with(1'b0, 1'b0);
      run_cells(8);
      disable_now();

      // Basic mode, 16-bit, full map (R10)
      cfg_portmap = 31'h7FFF_FFFF;
      fill_rdy(5, 2, 2);
      enable_with(1'b1, 1'b0);
      run_cells(8);
      disable_now();

      // Extended mode, 16-bit and 8-bit (R5)
      cfg_portmap = 31'h0F0F_00F3;
      fill_rdy(11, 4, 2);
      enable_with(1'b1, 1'b1);
      run_cells(10);
      disable_now();
      enable_with(1'b0, 1'b1);
      run_cells(5);
      disable_now();

      // Config change while enabled has no effect (R11)
      cfg_portmap = 31'h4000_8421;
      fill_rdy(2, 0, 4);
      enable_with(1'b0, 1'b0);
      run_cells(2);
      cfg_wide = 1'b1; cfg_ext = 1'b1;
      run_cells(4);
      disable_now();
      exp_wide = 1; exp_ext = 1;
      cfg_en = 1'b1;
      run_cells(3);
      disable_now();

      // Empty map: nothing polled or sent (R12)
      cfg_portmap = '0;
      enable_with(1'b1, 1'b1);
      begin
         int c0;
         c0 = n_cells;
         for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            chk(bus_addr == NULLA && bus_enb_n == 8'hFF, "R12 empty map idle",
                {bus_addr, bus_enb_n}, {NULLA, 8'hFF});
         end
         chk(n_cells == c0, "R12 no cell", n_cells, c0);
      end
      disable_now();

      finish_up();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_cells, 0);
      finish_up();
   end

endmodule